// File: doc/BRIEF.md
# Addressed Configuration Register Target on a Two-Wire Bus

This block is an I2C target that holds a small bank of control registers and returns a bank of live status values to a bus master. Four enable pins carry a code that selects one of eight 7-bit device addresses, 0x70 to 0x77. A code outside the eight valid ones keeps the target silent on the bus.

A write sends the device address, then a sub-address byte, then data bytes. Bit 7 of the sub-address turns on auto-increment, so that one transfer can fill a run of consecutive registers. A write that stops right after the sub-address only moves the internal pointer. A later read, either after a STOP and a new START or after a repeated START, begins at that pointer. Both bus lines are oversampled with the system clock. The target pulls SDA low through `sda_oe` and never drives it high.

Top module: `cfgbus_target`

## Requirements
- R1: The enable code `en_code` (bit 3 = first pin, bit 0 = fourth pin) selects the address. The codes 0100, 1100, 0010, 0110, 0101, 1101, 0011 and 0111 select 0x70 up to 0x77 in that order. The target ACKs an address byte whose upper 7 bits match the selected address.
- R2: `sda_oe` changes only while SCL is low.
- R3: The target gives no ACK when the address does not match or when `en_code` is not one of the eight valid codes. It then ignores every byte until the next START or STOP, and no register changes.
- R4: The target ACKs every data byte it accepts and stores it at the pointer. Sub-addresses 0x01 to 0x0F (low 7 bits) hold control registers 0 to 14. Control register k appears on `ctrl_o[8k+7:8k]`. Bytes go out and come in MSB first.
- R5: When sub-address bit 7 is 1, the pointer advances by one after each data byte written and after each byte read.
- R6: When sub-address bit 7 is 0, the target accepts only one data byte. It NACKs every later byte of that transfer and does not store it.
- R7: A read starts at the pointer left by the previous access. This holds also when that access was a write cut short after the sub-address. Without auto-increment, repeated reads return the same register.
- R8: Sub-addresses 0x10 to 0x16 read the live value of status byte j on `stat_i[8j+7:8j]`. Writes to these sub-addresses are ACKed but change nothing.
- R9: A repeated START placed after the sub-address begins a new address phase. The read that follows uses the pointer just set.
- R10: After reset, `ctrl_o` is all zeros, `sda_oe` is 0 and the pointer is 0.
- R11: Sub-addresses outside 0x01 to 0x16 read 0x00. Writes to them are ACKed and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_code | input | 4 | Enable-pin code that selects the device address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 |
| stat_i | input | 56 | Seven live status bytes |
| ctrl_o | output | 120 | Fifteen control register bytes |

## Verification
The assertions check on every cycle that SDA only moves while SCL is low and that the target stays off the bus while idle or skipping. They also check that the pointer steps by exactly the auto-increment flag on each stored byte and that writes aimed at status or unmapped addresses leave the control bank unchanged. Other behaviours show only in whole bus transfers run by the bench. These are the address table, NACK of a second byte in single-byte mode, where a read resumes after a truncated write or a repeated START, and the live status values.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_SKIP
   } bus_state_t;

   typedef enum logic [1:0] {
      RL_DEV, RL_SUB, RL_DATA
   } rx_role_t;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfgbus_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '1;
         else if (s == 0) chain[s] <= d_i;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cfgbus_addr_dec.sv
module cfgbus_addr_dec #(
   parameter logic [3:0] PREFIX = 4'b1110
) (
   input  logic [3:0] en_code,
   output logic [6:0] dev_addr,
   output logic       dev_valid
);
   logic [2:0] idx;

   always_comb begin
      dev_valid = 1'b1;
      idx       = 3'd0;
      unique case (en_code)
         4'b0100: idx = 3'd0;
         4'b1100: idx = 3'd1;
         4'b0010: idx = 3'd2;
         4'b0110: idx = 3'd3;
         4'b0101: idx = 3'd4;
         4'b1101: idx = 3'd5;
         4'b0011: idx = 3'd6;
         4'b0111: idx = 3'd7;
         default: dev_valid = 1'b0;
      endcase
      dev_addr = {PREFIX, idx};
   end
endmodule

// File: rtl/cfgbus_regfile.sv
module cfgbus_regfile #(
   parameter int N_CTRL     = 15,
   parameter int N_STAT     = 7,
   parameter int CTRL_BASE  = 1,
   parameter int PW         = 7,
   parameter bit STAT_FLOP  = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [PW-1:0]         ptr,
   input  logic [7:0]            wdata,
   input  logic [N_STAT*8-1:0]   stat_i,
   output logic [N_CTRL*8-1:0]   ctrl_o,
   output logic [7:0]            rdata
);
   localparam int STAT_BASE = CTRL_BASE + N_CTRL;

   if (STAT_BASE + N_STAT > (1 << PW)) begin : g_bad_map
      $error("cfgbus_regfile: register map exceeds pointer range");
   end

   logic [N_STAT*8-1:0] stat_v;
   logic [N_CTRL-1:0]   hit;

   if (STAT_FLOP) begin : g_stat_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_v <= '0;
         else        stat_v <= stat_i;
      end
   end else begin : g_stat_live
      assign stat_v = stat_i;
   end

   for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
      localparam logic [PW-1:0] MY_ADDR = PW'(CTRL_BASE + i);
      assign hit[i] = (ptr == MY_ADDR);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            ctrl_o[i*8 +: 8] <= '0;
         else if (we && hit[i]) ctrl_o[i*8 +: 8] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_CTRL; i++)
         if (ptr == PW'(CTRL_BASE + i)) rdata = ctrl_o[i*8 +: 8];
      for (int j = 0; j < N_STAT; j++)
         if (ptr == PW'(STAT_BASE + j)) rdata = stat_v[j*8 +: 8];
   end

   assert_status_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (hit == '0)) |=> (ctrl_o == $past(ctrl_o)));
endmodule

// File: rtl/cfgbus_target.sv
module cfgbus_target
   import cfgbus_pkg::*;
#(
   parameter int         N_CTRL      = 15,
   parameter int         N_STAT      = 7,
   parameter int         CTRL_BASE   = 1,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] ADDR_PREFIX = 4'b1110,
   parameter bit         STAT_FLOP   = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [3:0]                   en_code,
   input  logic                         scl_i,
   input  logic                         sda_i,
   output logic                         sda_oe,
   input  logic [N_STAT*BYTE_W-1:0]     stat_i,
   output logic [N_CTRL*BYTE_W-1:0]     ctrl_o
);
   localparam int PW = BYTE_W - 1;

   logic [1:0]    line_s;
   logic          scl_s, sda_s, scl_q, sda_q;
   logic          scl_rise, scl_fall, start_c, stop_c;
   logic [6:0]    dev_addr;
   logic          dev_valid;
   bus_state_t    state;
   rx_role_t      role;
   logic [7:0]    shreg;
   logic [3:0]    cnt;
   logic [PW-1:0] ptr;
   logic          inc, rd, got_one, macked, sda_oe_q;
   logic          wr_stb;
   logic [7:0]    rdata;

   cfgbus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(line_s));

   cfgbus_addr_dec #(.PREFIX(ADDR_PREFIX)) u_dec (
      .en_code(en_code), .dev_addr(dev_addr), .dev_valid(dev_valid));

   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

   assign wr_stb = (state == ST_RX) && (role == RL_DATA) && scl_fall &&
                   (cnt == 4'd8) && (inc || !got_one) && !start_c && !stop_c;

   cfgbus_regfile #(.N_CTRL(N_CTRL), .N_STAT(N_STAT), .CTRL_BASE(CTRL_BASE),
                    .PW(PW), .STAT_FLOP(STAT_FLOP)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(wr_stb), .ptr(ptr), .wdata(shreg),
      .stat_i(stat_i), .ctrl_o(ctrl_o), .rdata(rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         role     <= RL_DEV;
         shreg    <= '0;
         cnt      <= '0;
         ptr      <= '0;
         inc      <= 1'b0;
         rd       <= 1'b0;
         got_one  <= 1'b0;
         macked   <= 1'b0;
         sda_oe_q <= 1'b0;
      end else if (start_c) begin
         state    <= ST_RX;
         role     <= RL_DEV;
         cnt      <= '0;
         sda_oe_q <= 1'b0;
      end else if (stop_c) begin
         state    <= ST_IDLE;
         sda_oe_q <= 1'b0;
      end else begin
         unique case (state)
            ST_RX: begin
               if (scl_rise && cnt < 4'd8) begin
                  shreg <= {shreg[6:0], sda_s};
                  cnt   <= cnt + 4'd1;
               end else if (scl_fall && cnt == 4'd8) begin
                  unique case (role)
                     RL_DEV: begin
                        if (dev_valid && shreg[7:1] == dev_addr) begin
                           rd       <= shreg[0];
                           sda_oe_q <= 1'b1;
                           state    <= ST_ACK;
                        end else state <= ST_SKIP;
                     end
                     RL_SUB: begin
                        ptr      <= shreg[PW-1:0];
                        inc      <= shreg[7];
                        got_one  <= 1'b0;
                        sda_oe_q <= 1'b1;
                        state    <= ST_ACK;
                     end
                     default: begin
                        if (inc || !got_one) begin
                           ptr      <= ptr + PW'(inc);
                           got_one  <= 1'b1;
                           sda_oe_q <= 1'b1;
                           state    <= ST_ACK;
                        end else state <= ST_SKIP;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  cnt <= '0;
                  if (role == RL_DEV && rd) begin
                     shreg    <= rdata;
                     sda_oe_q <= ~rdata[7];
                     ptr      <= ptr + PW'(inc);
                     state    <= ST_TX;
                  end else begin
                     sda_oe_q <= 1'b0;
                     role     <= (role == RL_DEV) ? RL_SUB : RL_DATA;
                     state    <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (cnt == 4'd7) begin
                     sda_oe_q <= 1'b0;
                     state    <= ST_MACK;
                  end else begin
                     cnt      <= cnt + 4'd1;
                     shreg    <= {shreg[6:0], 1'b0};
                     sda_oe_q <= ~shreg[6];
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) macked <= ~sda_s;
               else if (scl_fall) begin
                  if (macked) begin
                     shreg    <= rdata;
                     sda_oe_q <= ~rdata[7];
                     ptr      <= ptr + PW'(inc);
                     cnt      <= '0;
                     state    <= ST_TX;
                  end else state <= ST_SKIP;
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe = sda_oe_q;

   assert_sda_moves_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe_q) && !$past(start_c) && !$past(stop_c)) |-> !scl_s);
   assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe_q);
   assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe_q);
   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (ptr == $past(ptr) + PW'($past(inc))));
   assert_bitcount_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= 4'd8);
endmodule

// File: tb/tb_cfgbus_target.sv
module tb_cfgbus_target;
   localparam int CLK_PERIOD = 10;
   localparam int H = 8;
   localparam int NV = 12;
   // {en_code, address, expect_ack}
   localparam logic [11:0] VEC [NV] = '{
      {4'b0100, 7'h70, 1'b1}, {4'b1100, 7'h71, 1'b1}, {4'b0010, 7'h72, 1'b1},
      {4'b0110, 7'h73, 1'b1}, {4'b0101, 7'h74, 1'b1}, {4'b1101, 7'h75, 1'b1},
      {4'b0011, 7'h76, 1'b1}, {4'b0111, 7'h77, 1'b1}, {4'b0100, 7'h71, 1'b0},
      {4'b0000, 7'h70, 1'b0}, {4'b1000, 7'h70, 1'b0}, {4'b1111, 7'h77, 1'b0}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic [3:0] en_code = 4'b0100;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic sda_oe;
   logic [55:0] stat_i = '0;
   logic [119:0] ctrl_o;
   wire sda_bus = m_sda & ~sda_oe;
   int total = 0, bad = 0, viol = 0, cyc = 0;
   logic prev_oe = 1'b0;
   logic ack;
   logic [7:0] rb;
   logic [119:0] snap;

   cfgbus_target dut (.clk(clk), .rst_n(rst_n), .en_code(en_code), .scl_i(m_scl),
      .sda_i(sda_bus), .sda_oe(sda_oe), .stat_i(stat_i), .ctrl_o(ctrl_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (sda_oe !== prev_oe && m_scl) viol++;
      prev_oe <= sda_oe;
      cyc++;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hw(input int n); repeat (n) @(negedge clk); endtask

   task automatic bus_start();
      if (!m_scl) begin
         m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H);
      end
      m_sda = 1'b0; hw(H); m_scl = 1'b0; hw(H);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; hw(H); m_scl = 1'b1; hw(H); m_sda = 1'b1; hw(H);
   endtask

   task automatic tx_byte(input logic [7:0] b, output logic a);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; hw(H); m_scl = 1'b1; hw(H); m_scl = 1'b0;
      end
      m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H/2); a = ~sda_bus; hw(H/2); m_scl = 1'b0;
   endtask

   task automatic rx_byte(input logic give_ack, output logic [7:0] d);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hw(H); m_scl = 1'b1; hw(H/2); d[i] = sda_bus; hw(H/2); m_scl = 1'b0;
      end
      m_sda = ~give_ack; hw(H); m_scl = 1'b1; hw(H); m_scl = 1'b0;
   endtask

   task automatic set_ptr(input logic [7:0] sub);
      logic a;
      bus_start(); tx_byte(8'hE0, a); tx_byte(sub, a); bus_stop();
   endtask

   task automatic read1(output logic [7:0] d);
      logic a;
      bus_start(); tx_byte(8'hE1, a); rx_byte(1'b0, d); bus_stop();
   endtask

   initial begin
      hw(5);
      chk(ctrl_o == '0, "R10 ctrl reset", ctrl_o, 0);
      chk(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
      rst_n = 1'b1; hw(5);

      // R1 / R3 address table
      foreach (VEC[k]) begin
         en_code = VEC[k][11:8];
         bus_start(); tx_byte({VEC[k][7:1], 1'b0}, ack); bus_stop();
         chk(ack == VEC[k][0], $sformatf("R1/R3 code %b addr %h", VEC[k][11:8], VEC[k][7:1]), ack, VEC[k][0]);
      end
      en_code = 4'b0100;

      // R10: pointer 0 after reset reads unmapped 0x00
      read1(rb); chk(rb == 8'h00, "R10 ptr zero read", rb, 0);

      // R6 single-byte write
      bus_start(); tx_byte(8'hE0, ack); tx_byte(8'h03, ack);
      tx_byte(8'hA5, ack); chk(ack, "R4 data ack", ack, 1);
      tx_byte(8'h5A, ack); chk(!ack, "R6 second byte nack", ack, 0);
      bus_stop();
      chk(ctrl_o[2*8 +: 8] == 8'hA5, "R4 ctrl2", ctrl_o[2*8 +: 8], 8'hA5);
      chk(ctrl_o[3*8 +: 8] == 8'h00, "R6 ctrl3 untouched", ctrl_o[3*8 +: 8], 0);

      // R5 auto-increment write
      bus_start(); tx_byte(8'hE0, ack); tx_byte(8'h85, ack);
      tx_byte(8'h11, ack); tx_byte(8'h22, ack); tx_byte(8'h33, ack); bus_stop();
      chk(ctrl_o[4*8 +: 24] == 24'h332211, "R5 burst write", ctrl_o[4*8 +: 24], 24'h332211);
      bus_start(); tx_byte(8'hE0, ack); tx_byte(8'h8F, ack); tx_byte(8'h9C, ack); bus_stop();
      chk(ctrl_o[14*8 +: 8] == 8'h9C, "R4 last ctrl reg", ctrl_o[14*8 +: 8], 8'h9C);

      // R7 truncated write then read, twice without increment
      set_ptr(8'h03);
      read1(rb); chk(rb == 8'hA5, "R7 read after ptr set", rb, 8'hA5);
      read1(rb); chk(rb == 8'hA5, "R7 ptr held", rb, 8'hA5);

      // R9 repeated start read with increment
      bus_start(); tx_byte(8'hE0, ack); tx_byte(8'h85, ack);
      bus_start(); tx_byte(8'hE1, ack); chk(ack, "R9 addr after Sr", ack, 1);
      rx_byte(1'b1, rb); chk(rb == 8'h11, "R9 byte0", rb, 8'h11);
      rx_byte(1'b1, rb); chk(rb == 8'h22, "R5 read inc byte1", rb, 8'h22);
      rx_byte(1'b0, rb); chk(rb == 8'h33, "R5 read inc byte2", rb, 8'h33);
      bus_stop();
      read1(rb); chk(rb == 8'h00, "R7 resume after burst", rb, 0);

      // R8 live status burst
      stat_i = 56'h77_66_55_44_33_22_11 ^ 56'h80_80_80_80_80_80_80;
      bus_start(); tx_byte(8'hE0, ack); tx_byte(8'h90, ack);
      bus_start(); tx_byte(8'hE1, ack);
      for (int j = 0; j < 7; j++) begin
         rx_byte(j != 6, rb);
         chk(rb == stat_i[j*8 +: 8], $sformatf("R8 status %0d", j), rb, stat_i[j*8 +: 8]);
      end
      bus_stop();
      stat_i[7:0] = 8'h3C;
      set_ptr(8'h10); read1(rb); chk(rb == 8'h3C, "R8 live update", rb, 8'h3C);

      // R8 write to status ignored
      snap = ctrl_o;
      bus_start(); tx_byte(8'hE0, ack); tx_byte(8'h10, ack); tx_byte(8'hFF, ack); bus_stop();
      chk(ack, "R8 status write acked", ack, 1);
      read1(rb); chk(rb == 8'h3C, "R8 status not written", rb, 8'h3C);
      chk(ctrl_o == snap, "R8 ctrl unchanged", ctrl_o, snap);

      // R11 unmapped addresses
      bus_start(); tx_byte(8'hE0, ack); tx_byte(8'h00, ack); tx_byte(8'h77, ack); bus_stop();
      chk(ack, "R11 unmapped write acked", ack, 1);
      chk(ctrl_o == snap, "R11 ctrl unchanged", ctrl_o, snap);
      set_ptr(8'h00); read1(rb); chk(rb == 8'h00, "R11 read 0x00", rb, 0);
      set_ptr(8'h20); read1(rb); chk(rb == 8'h00, "R11 read 0x20", rb, 0);

      // R3 wrong address: rest ignored
      bus_start(); tx_byte(8'hE2, ack); chk(!ack, "R3 wrong addr nack", ack, 0);
      tx_byte(8'h01, ack); chk(!ack, "R3 sub ignored", ack, 0);
      tx_byte(8'hCC, ack); chk(!ack, "R3 data ignored", ack, 0);
      bus_stop();
      chk(ctrl_o == snap, "R3 ctrl unchanged", ctrl_o, snap);

      chk(viol == 0, "R2 sda change while scl high", viol, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule